// File: doc/BRIEF.md
# StreamID Span Pattern Matcher

This unit decides whether the StreamID of an incoming transaction belongs to a programmed set of streams. Configuration arrives as three separate inputs: a filter enable, a span select and a 32-bit match value. With the span select low, the StreamID has to equal the match value in every bit. With the span select high, the match value carries its own don't-care field. A run of ones at the bottom of the value, together with the zero bit directly above that run, marks the StreamID bits that are ignored. The remaining upper bits have to match.

When the filter is disabled, the unit treats every StreamID as a match. This is the same as span mode with an all-ones value. The result is registered: a StreamID presented with its valid strobe produces the hit flag on the next cycle. The hit flag is low in any cycle that follows a cycle without a strobe. A counting block downstream uses the flag to decide whether an event belongs to the selected streams.

Top module: `sid_span_matcher`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no strobe pending, `sid_hit` is 0.
- R2: If `sid_vld` was 0 at a rising edge, `sid_hit` is 0 after that edge, whatever the StreamID and the configuration are.
- R3: With `filt_en`=1 and `span_mode`=0, `sid_hit` is 1 exactly when all 32 bits of `sid` equal `match_val`.
- R4: With `filt_en`=1 and `span_mode`=1, let T be the number of consecutive ones in `match_val` counted up from bit 0, and let Y = T+1. The low Y bits of `sid` are ignored. `sid_hit` is 1 exactly when bits Y and above of `sid` equal the same bits of `match_val`.
- R5: With span mode on and `match_val`=0x42, only StreamIDs 0x42 and 0x43 hit. 0x40, 0x41, 0x44 and 0x142 do not hit.
- R6: With span mode on and `match_val`=0xFFFFFFFF, every StreamID hits.
- R7: With `filt_en`=0, every strobed StreamID hits, whatever `span_mode` and `match_val` are.
- R8: The result for a strobed StreamID appears on `sid_hit` one cycle later. It uses the configuration present in the same cycle as the strobe, so back-to-back strobes give independent results on consecutive cycles.
- R9: With span mode on and `match_val`=0x7FFFFFFF (Y=32), every StreamID hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | 1 = apply the filter, 0 = every strobed StreamID hits |
| span_mode | input | 1 | 0 = exact compare, 1 = pattern compare with trailing don't-care field |
| match_val | input | 32 | Programmed match value |
| sid_vld | input | 1 | StreamID strobe |
| sid | input | 32 | Incoming StreamID |
| sid_hit | output | 1 | Registered match result, one cycle after the strobe |

## Verification
The StreamID is first set equal to the value and then flipped in its lowest and highest bit in exact mode. This separates a true all-bit compare from a compare that ignores bits.

In pattern mode, values ending in no ones, in three ones and in eight ones are each swept just inside and just outside their don't-care field. Any off-by-one in the field width would fail one of these sweeps.

Further patterns cover the all-ones value, the top-bit-clear value and the bypassed filter, which are the three ways every StreamID can hit. A cycle with the strobe low and a matching StreamID shows that the strobe gates the result. A pseudo-random stream of mixed configurations is compared against a trailing-ones model, which shows that each cycle's result depends only on that cycle's inputs.

// File: rtl/sidm_pkg.sv
package sidm_pkg;
  typedef enum logic [1:0] {
    MODE_ALL   = 2'd0,
    MODE_EXACT = 2'd1,
    MODE_SPAN  = 2'd2
  } sidm_mode_e;
endpackage

// File: rtl/sidm_cfg_select.sv
module sidm_cfg_select
  import sidm_pkg::*;
(
  input  logic       filt_en,
  input  logic       span_mode,
  output sidm_mode_e mode
);
  always_comb begin
    if (!filt_en)       mode = MODE_ALL;
    else if (span_mode) mode = MODE_SPAN;
    else                mode = MODE_EXACT;
  end
endmodule

// File: rtl/sidm_mask_gen.sv
module sidm_mask_gen
  import sidm_pkg::*;
#(
  parameter int SID_W = 32
) (
  input  sidm_mode_e       mode,
  input  logic [SID_W-1:0] value,
  output logic [SID_W-1:0] ign_mask
);
  // Trailing ones plus the zero above them: value ^ (value + 1).
  function automatic logic [SID_W-1:0] span_field(input logic [SID_W-1:0] v);
    logic [SID_W-1:0] inc;
    inc = v + SID_W'(1);
    return v ^ inc;
  endfunction

  always_comb begin
    unique case (mode)
      MODE_SPAN:  ign_mask = span_field(value);
      MODE_EXACT: ign_mask = '0;
      default:    ign_mask = '1;
    endcase
  end
endmodule

// File: rtl/sidm_compare.sv
module sidm_compare #(
  parameter int SID_W = 32
) (
  input  logic [SID_W-1:0] value,
  input  logic [SID_W-1:0] sid,
  input  logic [SID_W-1:0] ign_mask,
  output logic             hit
);
  function automatic logic masked_eq(input logic [SID_W-1:0] a,
                                     input logic [SID_W-1:0] b,
                                     input logic [SID_W-1:0] dc);
    return ((a ^ b) & ~dc) == '0;
  endfunction

  assign hit = masked_eq(value, sid, ign_mask);
endmodule

// File: rtl/sid_span_matcher.sv
module sid_span_matcher
  import sidm_pkg::*;
#(
  parameter int SID_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_en,
  input  logic             span_mode,
  input  logic [SID_W-1:0] match_val,
  input  logic             sid_vld,
  input  logic [SID_W-1:0] sid,
  output logic             sid_hit
);
  localparam logic [SID_W-1:0] ALL_ONES = '1;

  sidm_mode_e       mode;
  logic [SID_W-1:0] ign_mask;
  logic             raw_hit;

  sidm_cfg_select u_cfg (
    .filt_en   (filt_en),
    .span_mode (span_mode),
    .mode      (mode)
  );

  sidm_mask_gen #(.SID_W(SID_W)) u_mask (
    .mode     (mode),
    .value    (match_val),
    .ign_mask (ign_mask)
  );

  sidm_compare #(.SID_W(SID_W)) u_cmp (
    .value    (match_val),
    .sid      (sid),
    .ign_mask (ign_mask),
    .hit      (raw_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sid_hit <= 1'b0;
    else        sid_hit <= sid_vld & raw_hit;
  end

  // R4: the don't-care field is always a contiguous run from bit 0.
  a_r4_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ign_mask + SID_W'(1)));

  // R4: pattern mode always ignores at least bit 0.
  a_r4_mask_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && span_mode) |-> ign_mask[0]);

  // R6: an all-ones value in pattern mode ignores every bit.
  a_r6_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && span_mode && match_val == ALL_ONES) |-> (ign_mask == ALL_ONES));

  // R2: no strobe, no hit.
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sid_vld |=> !sid_hit);

  // R7: bypassed filter hits on every strobe.
  a_r7_bypass_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (sid_vld && !filt_en) |=> sid_hit);

  // R3: exact mode, equal StreamID hits.
  a_r3_exact_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (sid_vld && filt_en && !span_mode && sid == match_val) |=> sid_hit);

  // R3: exact mode, any differing bit misses.
  a_r3_exact_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (sid_vld && filt_en && !span_mode && sid != match_val) |=> !sid_hit);
endmodule

// File: tb/test_sid_span_matcher.sv
module test_sid_span_matcher;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        filt_en = 1'b0;
  logic        span_mode = 1'b0;
  logic [31:0] match_val = '0;
  logic        sid_vld = 1'b0;
  logic [31:0] sid = '0;
  logic        sid_hit;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit exp_q[$];
  string tag_q[$];

  sid_span_matcher i_sid_span_matcher (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .span_mode(span_mode),
    .match_val(match_val), .sid_vld(sid_vld), .sid(sid), .sid_hit(sid_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: count trailing ones, ignore that many bits plus one.
  function automatic bit model(bit en, bit sp, logic [31:0] v, logic [31:0] s);
    int y;
    if (!en) return 1'b1;
    if (!sp) return v == s;
    y = 0;
    while (y < 32 && v[y]) y++;
    y = y + 1;
    if (y >= 32) return 1'b1;
    return (v >> y) == (s >> y);
  endfunction

  task automatic check(string tag, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, bit en, bit sp, logic [31:0] v,
                       bit vld, logic [31:0] s);
    @(negedge clk);
    filt_en = en; span_mode = sp; match_val = v; sid_vld = vld; sid = s;
    exp_q.push_back(vld ? model(en, sp, v, s) : 1'b0);
    tag_q.push_back(tag);
  endtask

  // Monitor: results come one edge after the drive.
  initial begin
    wait (started);
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), sid_hit, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL R8 watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    // R1: strobe with bypassed filter during reset must not hit.
    filt_en = 1'b0; sid_vld = 1'b1; sid = 32'h1234;
    repeat (3) @(posedge clk);
    #1 check("R1 during reset", sid_hit, 1'b0);
    @(negedge clk); sid_vld = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after reset", sid_hit, 1'b0);
    started = 1;

    drive("R7 bypass val0",     0, 0, 32'h0,        1, 32'h0000_1234);
    drive("R7 bypass span",     0, 1, 32'h42,       1, 32'hFFFF_FFFF);
    drive("R3 exact equal",     1, 0, 32'hDEAD_BEEF, 1, 32'hDEAD_BEEF);
    drive("R3 exact bit0",      1, 0, 32'hDEAD_BEEF, 1, 32'hDEAD_BEEE);
    drive("R3 exact bit31",     1, 0, 32'hDEAD_BEEF, 1, 32'h5EAD_BEEF);
    drive("R2 idle match",      1, 0, 32'hDEAD_BEEF, 0, 32'hDEAD_BEEF);
    drive("R2 idle bypass",     0, 0, 32'h0,         0, 32'h0);
    drive("R5 0x42",            1, 1, 32'h42, 1, 32'h42);
    drive("R5 0x43",            1, 1, 32'h42, 1, 32'h43);
    drive("R5 0x40",            1, 1, 32'h42, 1, 32'h40);
    drive("R5 0x41",            1, 1, 32'h42, 1, 32'h41);
    drive("R5 0x44",            1, 1, 32'h42, 1, 32'h44);
    drive("R5 0x142",           1, 1, 32'h42, 1, 32'h142);
    drive("R4 y4 low",          1, 1, 32'h1237, 1, 32'h1230);
    drive("R4 y4 high",         1, 1, 32'h1237, 1, 32'h123F);
    drive("R4 y4 above",        1, 1, 32'h1237, 1, 32'h1240);
    drive("R4 y4 below",        1, 1, 32'h1237, 1, 32'h1220);
    drive("R4 y9 in",           1, 1, 32'h0FF,  1, 32'h1FF);
    drive("R4 y9 out",          1, 1, 32'h0FF,  1, 32'h200);
    drive("R6 ones sid0",       1, 1, 32'hFFFF_FFFF, 1, 32'h0);
    drive("R6 ones any",        1, 1, 32'hFFFF_FFFF, 1, 32'hABCD_EF01);
    drive("R9 y32 allset",      1, 1, 32'h7FFF_FFFF, 1, 32'hFFFF_FFFF);
    drive("R9 y32 zero",        1, 1, 32'h7FFF_FFFF, 1, 32'h0);
    // R8: back-to-back alternation with configuration changing each cycle.
    drive("R8 b2b hit",         1, 0, 32'h55, 1, 32'h55);
    drive("R8 b2b miss",        1, 1, 32'h42, 1, 32'h44);
    drive("R8 b2b hit2",        0, 0, 32'h1,  1, 32'h2);
    drive("R8 b2b miss2",       1, 0, 32'h1,  1, 32'h2);
    r = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] v, s;
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      v = {r[31:8], 8'h0} | ((32'h1 << r[4:0]) - 32'h1);
      s = r[5] ? (v ^ (r & 32'h3F)) : (v ^ 32'h0100_0000);
      drive("R4 random", r[31] | r[30], r[29], v, r[28] | r[27], s);
    end
    drive("R2 tail idle", 1, 0, 32'h0, 0, 32'h0);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule